// File: doc/BRIEF.md
# Polled Ingress Dispatcher with Processor Packet Queue

This block sits between a set of input ports and a shared packet buffer. A round-robin pointer visits one input per clock cycle, in fixed order, and at most one packet header is taken in that cycle. When the visited input offers a packet, the block takes one address from an external free-address pool. It then issues a single store command for that address, so the packet body lands in the buffer exactly once. After that it fans the address out to the external output queues.

A header carries a destination bitmap with one bit per output and a 2-bit priority, where 0 is the most urgent. A data packet with several bits set pushes the same address into every flagged output queue, all at its one priority. A header whose bitmap is all zero is meant for the local processor, and its priority is ignored. Its address is stored and then entered into an internal processor queue of bounded depth, and an interrupt is raised toward the processor. If that queue is already full, the packet is thrown away and a sticky overflow flag is set.

The input headers and the free-address supply use valid/ready handshakes. An input must hold `in_valid` and its header stable until it sees `in_ready` for its own index. `in_ready` can only rise while the pointer sits on that input, so a stalled input waits one full rotation for its next chance. The free-address pool must hold `fa_addr` while `fa_valid` is high, and it is popped in any cycle where `fa_valid` and `fa_ready` are both high. The store, queue-push and processor-queue pins are plain strobes with no back-pressure.

Top module: `ingress_dispatch`

## Requirements
- R1: After reset the poll pointer is 0. It advances by one every cycle and wraps from N_IN-1 to 0. `in_ready` is only asserted for the input the pointer is on, and at most one `in_ready` bit is high in any cycle.
- R2: The input at the pointer gets `in_ready` only when all of the following hold: its `in_valid` is high, and either a free address is offered (`fa_valid`) or the packet is a processor packet that will be dropped. An input that is not served waits for its next visit. Without `in_valid` the input is skipped.
- R3: One cycle after an accepted (non-dropped) handshake, `st_valid` pulses for exactly one cycle. At the same time `st_addr` shows the address taken from the pool, and `st_src` shows the input index.
- R4: For a data packet (bitmap non-zero, bit i = output i), the cycle after acceptance shows all of the following: `q_push` equal to the bitmap, `q_prio` equal to the header priority, `q_addr` equal to the stored address, and `glob_inc` high.
- R5: For a header with an all-zero bitmap, the cycle after acceptance shows `st_ctl` high, `q_push` all zero and `glob_inc` low. The stored address is entered into the processor queue.
- R6: The processor queue hands out addresses in arrival order. `ctl_addr` shows the oldest entry and `ctl_count` shows the number of entries. A high `ctl_rd` removes one entry, and it has no effect when the queue is empty. `irq` is high exactly while `ctl_count` is non-zero.
- R7: The processor queue holds CTL_DEPTH (default 16) entries. A processor packet that arrives while the queue already holds CTL_DEPTH entries is still handshaken, but it takes no address, issues no store and sets `ovf`. Fullness is judged on the count before any `ctl_rd` in the same cycle.
- R8: `ovf` stays set until a cycle with `ovf_clr` high and no new drop. If a drop and `ovf_clr` fall in the same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | N_IN | Header offered, one bit per input |
| in_ready | output | N_IN | Header taken, one bit per input |
| in_dest | input | N_IN*N_OUT | Destination bitmaps, input i at bits [i*N_OUT +: N_OUT] |
| in_prio | input | N_IN*PRIO_W | Priorities, input i at bits [i*PRIO_W +: PRIO_W], 0 most urgent |
| fa_valid | input | 1 | Free address available |
| fa_ready | output | 1 | Free address consumed this cycle |
| fa_addr | input | ADDR_W | Free buffer address |
| st_valid | output | 1 | Store command strobe |
| st_addr | output | ADDR_W | Buffer address to store into |
| st_src | output | SRC_W | Input index whose data is stored |
| st_ctl | output | 1 | Stored packet is a processor packet |
| q_push | output | N_OUT | Per-output queue push strobes |
| q_prio | output | PRIO_W | Priority for the pushed address |
| q_addr | output | ADDR_W | Address pushed to output queues |
| glob_inc | output | 1 | Data packet stored (global occupancy increment) |
| ctl_addr | output | ADDR_W | Oldest address in the processor queue |
| ctl_count | output | CNT_W | Processor queue occupancy |
| ctl_rd | input | 1 | Processor pop strobe |
| irq | output | 1 | Processor queue non-empty |
| ovf | output | 1 | Processor packet dropped since last clear |
| ovf_clr | input | 1 | Clear request for `ovf` |

## Verification
The processor queue can receive a new entry and lose its head to `ctl_rd` in the same cycle. At the full boundary, this combination decides whether the incoming packet is dropped or kept. The bench fills the queue to its limit, then raises `ctl_rd` in the exact cycle the pointer accepts another processor packet. It judges the result by the drop, the unchanged free-address pool and a count of one less. The sticky flag also meets a set and a clear together: `ovf_clr` is driven in the cycle of a fresh drop, and `ovf` must still read high afterwards.

// File: rtl/ingr_pkg.sv
package ingr_pkg;

  // Decision taken for the input under the poll pointer in one cycle
  typedef enum logic [1:0] {
    ACT_IDLE = 2'd0,
    ACT_DATA = 2'd1,
    ACT_CTRL = 2'd2,
    ACT_DROP = 2'd3
  } act_e;

  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/ingr_poll.sv
module ingr_poll
  import ingr_pkg::*;
#(
  parameter int N_IN   = 4,
  parameter int N_OUT  = 4,
  parameter int PRIO_W = 2,
  parameter int SRC_W  = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [N_IN-1:0]         in_valid,
  input  logic [N_IN*N_OUT-1:0]   in_dest,
  input  logic [N_IN*PRIO_W-1:0]  in_prio,
  input  logic                    ctl_full,
  input  logic                    fa_valid,
  output logic [N_IN-1:0]         in_ready,
  output act_e                    act,
  output logic [SRC_W-1:0]        sel_src,
  output logic [N_OUT-1:0]        sel_dest,
  output logic [PRIO_W-1:0]       sel_prio
);

  localparam logic [SRC_W-1:0] LAST = SRC_W'(N_IN - 1);

  logic [SRC_W-1:0] ptr;
  logic             sel_valid;

  always_ff @(posedge clk) begin
    if (rst)               ptr <= '0;
    else if (ptr == LAST)  ptr <= '0;
    else                   ptr <= ptr + 1'b1;
  end

  assign sel_src   = ptr;
  assign sel_valid = in_valid[ptr];
  assign sel_dest  = in_dest[ptr*N_OUT +: N_OUT];
  assign sel_prio  = in_prio[ptr*PRIO_W +: PRIO_W];

  always_comb begin
    act = ACT_IDLE;
    if (sel_valid) begin
      if (sel_dest == '0) begin
        if (ctl_full)      act = ACT_DROP;
        else if (fa_valid) act = ACT_CTRL;
      end else if (fa_valid) begin
        act = ACT_DATA;
      end
    end
  end

  for (genvar i = 0; i < N_IN; i++) begin : g_rdy
    assign in_ready[i] = (ptr == SRC_W'(i)) && (act != ACT_IDLE);
  end

  p_one_ready_r1: assert property (@(posedge clk) disable iff (rst)
    $onehot0(in_ready)) else $error("more than one input served");

  p_ptr_step_r1: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ptr == (($past(ptr) == LAST) ? '0 : $past(ptr) + 1'b1))
    else $error("poll pointer did not advance by one");

  p_ready_needs_valid_r2: assert property (@(posedge clk) disable iff (rst)
    (|in_ready) |-> (|(in_ready & in_valid)))
    else $error("ready given to an input without valid");

endmodule

// File: rtl/ingr_ctlq.sv
module ingr_ctlq #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 6,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [DATA_W-1:0] head,
  output logic [CNT_W-1:0]  count,
  output logic              full
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PW-1:0]     wp, rp;
  logic              do_pop;

  assign full   = (count == CNT_W'(DEPTH));
  assign do_pop = pop && (count != '0);
  assign head   = mem[rp];

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (push)   wp <= (wp == LAST) ? '0 : wp + 1'b1;
      if (do_pop) rp <= (rp == LAST) ? '0 : rp + 1'b1;
      case ({push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
    count <= CNT_W'(DEPTH)) else $error("processor queue over capacity");

  p_push_room_r7: assert property (@(posedge clk) disable iff (rst)
    push |-> !full) else $error("push into full processor queue");

  p_pop_empty_r6: assert property (@(posedge clk) disable iff (rst)
    (pop && count == '0 && !push) |=> count == '0)
    else $error("pop on empty queue changed the count");

endmodule

// File: rtl/ingr_emit.sv
module ingr_emit
  import ingr_pkg::*;
#(
  parameter int N_OUT  = 4,
  parameter int PRIO_W = 2,
  parameter int ADDR_W = 6,
  parameter int SRC_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  act_e              act,
  input  logic [SRC_W-1:0]  src,
  input  logic [N_OUT-1:0]  dest,
  input  logic [PRIO_W-1:0] prio,
  input  logic [ADDR_W-1:0] addr,
  output logic              st_valid,
  output logic [ADDR_W-1:0] st_addr,
  output logic [SRC_W-1:0]  st_src,
  output logic              st_ctl,
  output logic [N_OUT-1:0]  q_push,
  output logic [PRIO_W-1:0] q_prio,
  output logic [ADDR_W-1:0] q_addr,
  output logic              glob_inc
);

  logic is_data, is_ctrl;
  assign is_data = (act == ACT_DATA);
  assign is_ctrl = (act == ACT_CTRL);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_valid <= 1'b0;
      st_addr  <= '0;
      st_src   <= '0;
      st_ctl   <= 1'b0;
      q_push   <= '0;
      q_prio   <= '0;
      q_addr   <= '0;
      glob_inc <= 1'b0;
    end else begin
      st_valid <= is_data || is_ctrl;
      st_ctl   <= is_ctrl;
      glob_inc <= is_data;
      q_push   <= is_data ? dest : '0;
      if (is_data || is_ctrl) begin
        st_addr <= addr;
        st_src  <= src;
      end
      if (is_data) begin
        q_prio <= prio;
        q_addr <= addr;
      end
    end
  end

  p_push_has_store_r4: assert property (@(posedge clk) disable iff (rst)
    (|q_push) |-> (st_valid && !st_ctl && glob_inc && q_addr == st_addr))
    else $error("queue push without matching data store");

  p_ctl_no_fanout_r5: assert property (@(posedge clk) disable iff (rst)
    st_ctl |-> (st_valid && q_push == '0 && !glob_inc))
    else $error("processor packet pushed to output queues");

endmodule

// File: rtl/ingress_dispatch.sv
module ingress_dispatch
  import ingr_pkg::*;
#(
  parameter int N_IN      = 4,
  parameter int N_OUT     = 4,
  parameter int PRIO_W    = 2,
  parameter int ADDR_W    = 6,
  parameter int CTL_DEPTH = 16,
  parameter int SRC_W     = idx_width(N_IN),
  parameter int CNT_W     = $clog2(CTL_DEPTH + 1)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [N_IN-1:0]         in_valid,
  output logic [N_IN-1:0]         in_ready,
  input  logic [N_IN*N_OUT-1:0]   in_dest,
  input  logic [N_IN*PRIO_W-1:0]  in_prio,
  input  logic                    fa_valid,
  output logic                    fa_ready,
  input  logic [ADDR_W-1:0]       fa_addr,
  output logic                    st_valid,
  output logic [ADDR_W-1:0]       st_addr,
  output logic [SRC_W-1:0]        st_src,
  output logic                    st_ctl,
  output logic [N_OUT-1:0]        q_push,
  output logic [PRIO_W-1:0]       q_prio,
  output logic [ADDR_W-1:0]       q_addr,
  output logic                    glob_inc,
  output logic [ADDR_W-1:0]       ctl_addr,
  output logic [CNT_W-1:0]        ctl_count,
  input  logic                    ctl_rd,
  output logic                    irq,
  output logic                    ovf,
  input  logic                    ovf_clr
);

  act_e              act;
  logic [SRC_W-1:0]  sel_src;
  logic [N_OUT-1:0]  sel_dest;
  logic [PRIO_W-1:0] sel_prio;
  logic              ctl_full;

  ingr_poll #(
    .N_IN(N_IN), .N_OUT(N_OUT), .PRIO_W(PRIO_W), .SRC_W(SRC_W)
  ) u_poll (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_dest(in_dest), .in_prio(in_prio),
    .ctl_full(ctl_full), .fa_valid(fa_valid),
    .in_ready(in_ready), .act(act),
    .sel_src(sel_src), .sel_dest(sel_dest), .sel_prio(sel_prio)
  );

  assign fa_ready = (act == ACT_DATA) || (act == ACT_CTRL);

  ingr_ctlq #(
    .DEPTH(CTL_DEPTH), .DATA_W(ADDR_W), .CNT_W(CNT_W)
  ) u_ctlq (
    .clk(clk), .rst(rst),
    .push(act == ACT_CTRL), .push_data(fa_addr),
    .pop(ctl_rd),
    .head(ctl_addr), .count(ctl_count), .full(ctl_full)
  );

  assign irq = (ctl_count != '0);

  ingr_emit #(
    .N_OUT(N_OUT), .PRIO_W(PRIO_W), .ADDR_W(ADDR_W), .SRC_W(SRC_W)
  ) u_emit (
    .clk(clk), .rst(rst),
    .act(act), .src(sel_src), .dest(sel_dest), .prio(sel_prio), .addr(fa_addr),
    .st_valid(st_valid), .st_addr(st_addr), .st_src(st_src), .st_ctl(st_ctl),
    .q_push(q_push), .q_prio(q_prio), .q_addr(q_addr), .glob_inc(glob_inc)
  );

  // Sticky drop flag: a new drop wins over a same-cycle clear
  always_ff @(posedge clk) begin
    if (rst)                  ovf <= 1'b0;
    else if (act == ACT_DROP) ovf <= 1'b1;
    else if (ovf_clr)         ovf <= 1'b0;
  end

  p_drop_effects_r7: assert property (@(posedge clk) disable iff (rst)
    (act == ACT_DROP) |=> (ovf && !st_valid))
    else $error("drop did not flag or still stored");

  p_drop_no_addr_r7: assert property (@(posedge clk) disable iff (rst)
    (act == ACT_DROP) |-> !fa_ready)
    else $error("dropped packet consumed an address");

  p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    (ovf && !ovf_clr) |=> ovf)
    else $error("overflow flag lost without clear");

  p_irq_count_r6: assert property (@(posedge clk) disable iff (rst)
    (act == ACT_CTRL) |=> irq)
    else $error("interrupt missing after processor packet");

endmodule

// File: tb/test_ingress_dispatch.sv
module test_ingress_dispatch;

  localparam int N = 4;
  localparam int NO = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0]    in_valid = '0;
  logic [N-1:0]    in_ready;
  logic [N*NO-1:0] in_dest = '0;
  logic [N*2-1:0]  in_prio = '0;
  logic            fa_valid = 1'b1;
  logic            fa_ready;
  logic [5:0]      fa_next;
  logic            st_valid, st_ctl, glob_inc, irq, ovf;
  logic [5:0]      st_addr, q_addr, ctl_addr;
  logic [1:0]      st_src, q_prio;
  logic [NO-1:0]   q_push;
  logic [4:0]      ctl_count;
  logic            ctl_rd = 1'b0;
  logic            ovf_clr = 1'b0;

  int checks = 0;
  int fails = 0;
  int wd = 0;
  logic [1:0] mptr;
  logic [5:0] expq [64];
  int qwr = 0, qrd = 0, exp_cnt = 0;

  always #10 clk = ~clk;

  ingress_dispatch i_ingress_dispatch (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_dest(in_dest), .in_prio(in_prio), .fa_valid(fa_valid), .fa_ready(fa_ready),
    .fa_addr(fa_next), .st_valid(st_valid), .st_addr(st_addr), .st_src(st_src),
    .st_ctl(st_ctl), .q_push(q_push), .q_prio(q_prio), .q_addr(q_addr),
    .glob_inc(glob_inc), .ctl_addr(ctl_addr), .ctl_count(ctl_count), .ctl_rd(ctl_rd),
    .irq(irq), .ovf(ovf), .ovf_clr(ovf_clr)
  );

  // Environment: free-address pool counting up, and the expected poll position
  always @(posedge clk) begin
    if (rst) begin
      fa_next <= 6'd0;
      mptr    <= 2'd0;
    end else begin
      if (fa_valid && fa_ready) fa_next <= fa_next + 6'd1;
      mptr <= mptr + 2'd1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd >= 100000) begin
      chk(1'b0, "R1", "watchdog", wd, 100000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  // Offer one header and follow it through; port/dest/prio, optional same-cycle pop/clear
  task automatic send(input int port, input logic [3:0] dest, input logic [1:0] prio,
                      input bit pop, input bit clr, input bit exp_drop);
    int waited = 0;
    bit got = 0;
    logic [5:0] ea = '0;
    @(negedge clk);
    in_valid[port] = 1'b1;
    in_dest[port*NO +: NO] = dest;
    in_prio[port*2 +: 2] = prio;
    while (!got && waited < 3*N) begin
      #1;
      if (in_ready[port]) begin
        got = 1;
        chk(int'(mptr) == port, "R1", "served off its slot", int'(mptr), port);
        chk($countones(in_ready) == 1, "R1", "ready count", $countones(in_ready), 1);
        ea = fa_next;
        ctl_rd = pop;
        ovf_clr = clr;
      end else begin
        @(negedge clk);
        waited++;
      end
    end
    chk(got, "R2", "header never accepted", int'(got), 1);
    if (!got) return;
    @(negedge clk);
    in_valid[port] = 1'b0;
    ctl_rd = 1'b0;
    ovf_clr = 1'b0;
    if (pop) begin qrd++; exp_cnt--; end
    if (exp_drop) begin
      chk(st_valid == 1'b0, "R7", "store on drop", int'(st_valid), 0);
      chk(ovf == 1'b1, "R7", "ovf after drop", int'(ovf), 1);
      chk(fa_next == ea, "R7", "address taken on drop", int'(fa_next), int'(ea));
    end else if (dest == 4'b0) begin
      expq[qwr] = ea; qwr++; exp_cnt++;
      chk(st_valid && st_ctl, "R5", "ctl store flags", int'({st_valid, st_ctl}), 3);
      chk(st_addr == ea, "R3", "ctl store addr", int'(st_addr), int'(ea));
      chk(q_push == '0 && !glob_inc, "R5", "ctl fan-out", int'(q_push), 0);
    end else begin
      chk(st_valid && !st_ctl, "R3", "data store flags", int'({st_valid, st_ctl}), 2);
      chk(st_addr == ea && int'(st_src) == port, "R3", "store addr/src",
          int'(st_addr), int'(ea));
      chk(q_push == dest, "R4", "push bitmap", int'(q_push), int'(dest));
      chk(q_prio == prio && q_addr == ea, "R4", "push prio/addr", int'(q_addr), int'(ea));
      chk(glob_inc, "R4", "global increment", int'(glob_inc), 1);
    end
    chk(int'(ctl_count) == exp_cnt, "R6", "ctl count", int'(ctl_count), exp_cnt);
    chk(irq == (exp_cnt != 0), "R6", "irq level", int'(irq), int'(exp_cnt != 0));
    @(negedge clk);
    chk(st_valid == 1'b0, "R3", "store strobe length", int'(st_valid), 0);
  endtask

  // {port[7:6], dest[5:2], prio[1:0]}
  localparam logic [7:0] VEC [6] = '{
    {2'd0, 4'b0001, 2'd0},
    {2'd1, 4'b1011, 2'd2},
    {2'd3, 4'b1111, 2'd3},
    {2'd2, 4'b0100, 2'd1},
    {2'd1, 4'b0000, 2'd2},
    {2'd3, 4'b0010, 2'd0}
  };

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // Reset state
    chk(in_ready == '0 && !fa_ready, "R2", "idle ready", int'(in_ready), 0);
    chk(!st_valid && q_push == '0 && !glob_inc, "R3", "idle store", int'(st_valid), 0);
    chk(ctl_count == '0 && !irq && !ovf, "R6", "reset queue", int'(ctl_count), 0);

    // Table walk: unicast, multicast, broadcast, one processor packet
    for (int v = 0; v < 6; v++)
      send(int'(VEC[v][7:6]), VEC[v][5:2], VEC[v][1:0], 1'b0, 1'b0, 1'b0);

    // Fill the processor queue to capacity
    while (exp_cnt < 16) send(exp_cnt % N, 4'b0000, 2'd1, 1'b0, 1'b0, 1'b0);
    chk(ctl_count == 5'd16, "R7", "queue full", int'(ctl_count), 16);

    // Overflow drop
    send(2, 4'b0000, 2'd0, 1'b0, 1'b0, 1'b1);
    // Clear, then a drop with a same-cycle pop at full
    @(negedge clk); ovf_clr = 1'b1;
    @(negedge clk); ovf_clr = 1'b0;
    chk(ovf == 1'b0, "R8", "ovf cleared", int'(ovf), 0);
    send(1, 4'b0000, 2'd0, 1'b1, 1'b0, 1'b1);
    chk(ctl_count == 5'd15, "R7", "pop with drop", int'(ctl_count), 15);
    // Refill the freed slot, then a drop with a same-cycle clear
    send(0, 4'b0000, 2'd0, 1'b0, 1'b0, 1'b0);
    send(3, 4'b0000, 2'd0, 1'b0, 1'b1, 1'b1);
    chk(ovf == 1'b1, "R8", "set beats clear", int'(ovf), 1);

    // Drain in order
    while (exp_cnt > 0) begin
      @(negedge clk); #1;
      chk(ctl_addr == expq[qrd], "R6", "pop order", int'(ctl_addr), int'(expq[qrd]));
      ctl_rd = 1'b1;
      @(negedge clk); ctl_rd = 1'b0;
      qrd++; exp_cnt--;
      chk(int'(ctl_count) == exp_cnt, "R6", "drain count", int'(ctl_count), exp_cnt);
    end
    chk(!irq, "R6", "irq after drain", int'(irq), 0);
    @(negedge clk); ctl_rd = 1'b1;
    @(negedge clk); ctl_rd = 1'b0;
    chk(ctl_count == '0 && !irq, "R6", "read on empty", int'(ctl_count), 0);

    // No free address: data packet must wait across full rotations
    @(negedge clk);
    fa_valid = 1'b0;
    in_valid[2] = 1'b1; in_dest[2*NO +: NO] = 4'b1000; in_prio[4 +: 2] = 2'd1;
    for (int c = 0; c < 2*N; c++) begin
      #1;
      chk(in_ready == '0, "R2", "ready without address", int'(in_ready), 0);
      @(negedge clk);
      chk(!st_valid, "R2", "store without address", int'(st_valid), 0);
    end
    in_valid[2] = 1'b0;
    fa_valid = 1'b1;
    send(2, 4'b1000, 2'd1, 1'b0, 1'b0, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule